// File: doc/BRIEF.md
# Reset Sequencer with Sticky Cause Flags

This block gathers every reset request of a small microcontroller into a single chip reset. The requests are power-on, the external reset pin, watchdog expiry, brown-out, a software reset instruction, and the stack-full and stack-underflow events. Each arrives as a synchronous pulse or level on the fast system clock. Power-on and an enabled brown-out both hold the chip in reset until a power-up delay has run out. The delay is counted in ticks of a slow internal oscillator, and each tick is presented as a one-cycle enable. The default length is 2048 ticks, which is the full range of an 11-bit counter. Every other request holds the chip reset only while it is present, plus one cycle.

Firmware reads a status byte of sticky cause flags and clears them by writing zeros. The same byte holds a plain read/write interrupt-priority enable. A separate 3-bit cause code identifies the most recent request among eight kinds. This includes whether a pin reset arrived during normal run or during a power-managed (sleep/idle) mode. Power-on acts as the block's own asynchronous reset.

Top module: `reset_sequencer`

## Requirements
- R1: While `por_req` is high and directly after it, `chip_rst` is 1, `reset_cause` is 0 (power-on), the priority enable is 0, and the status byte reads 0x01 (only the power-on flag set).
- R2: After `por_req` falls, `chip_rst` stays 1 until the clock edge that samples the PU_TICKS-th `lf_tick` pulse, and it is 0 from that edge onward. Cycles without `lf_tick` do not advance the delay.
- R3: A pin, watchdog, software or stack request makes `chip_rst` 1 from the next edge for as long as the request lasts, plus one cycle. Such a request does not restart a running power-up delay.
- R4: `bor_detect` has no effect (no flag, no reset, no cause update) while `bor_enable` is 0. When `bor_enable` is 1, it sets the brown-out flag and restarts the full power-up delay.
- R5: Status flag positions are bit0 power-on, bit1 brown-out, bit2 watchdog, bit3 software instruction, and bit4 stack (full or underflow). An event sets its flag at the next edge.
- R6: A write with a 0 in flag bit k clears that flag, and a 1 leaves it unchanged. An event that sets a flag in the same cycle as a clear of it leaves the flag set.
- R7: Status bit7 is the interrupt-priority enable and takes `reg_wdata[7]` on every write. Bits 6:5 always read 0.
- R8: `reg_rdata` takes the status byte as it stood before an edge at which `reg_re` is 1. It holds its value when `reg_re` is 0 and is 0 after power-on.
- R9: `reset_cause` is updated on every cycle with a request and encodes 1 pin/run, 2 pin/sleep, 3 watchdog, 4 brown-out, 5 software, 6 stack full, 7 stack underflow. Simultaneous requests resolve in the order brown-out, watchdog, pin, software, stack full, stack underflow.
- R10: A pin request is coded 2 when `in_sleep` is 1 and 1 otherwise, and it sets no status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_req | input | 1 | Power-on pulse, asynchronous block reset |
| lf_tick | input | 1 | One-cycle enable per slow-oscillator period |
| ext_rst_req | input | 1 | External reset pin request |
| in_sleep | input | 1 | Core is in a power-managed mode |
| wdt_expire | input | 1 | Watchdog time-out |
| bor_detect | input | 1 | Brown-out detected |
| bor_enable | input | 1 | Brown-out reset enable |
| sw_reset | input | 1 | Software reset instruction |
| stk_full | input | 1 | Stack-full event |
| stk_underflow | input | 1 | Stack-underflow event |
| reg_we | input | 1 | Status write enable |
| reg_wdata | input | 8 | Status write data |
| reg_re | input | 1 | Status read enable |
| reg_rdata | output | 8 | Status read data, one cycle latency |
| reset_cause | output | 3 | Code of the latest reset request |
| chip_rst | output | 1 | Merged chip reset, active high |

## Verification
A power-up counter that runs off by one tick, or that counts fast-clock cycles instead of ticks, shows up as a `chip_rst` falling edge that is one tick early or late. Because the release edge is compared exactly, this is visible in the very cycle the delay should end. A lost or stuck flag appears on the next read of the status byte, and a wrong merge appears on `chip_rst` one cycle after the offending request. An inverted clear or a wrong set-versus-clear precedence shows in the read that follows the write, and a bad priority order shows on `reset_cause` one edge after simultaneous requests.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

  typedef enum logic [2:0] {
    CAUSE_POWERON   = 3'd0,
    CAUSE_PIN_RUN   = 3'd1,
    CAUSE_PIN_SLEEP = 3'd2,
    CAUSE_WATCHDOG  = 3'd3,
    CAUSE_BROWNOUT  = 3'd4,
    CAUSE_SOFTWARE  = 3'd5,
    CAUSE_STK_FULL  = 3'd6,
    CAUSE_STK_UNDER = 3'd7
  } cause_e;

  localparam int FLAG_W   = 5;
  localparam int FLG_POR  = 0;
  localparam int FLG_BOR  = 1;
  localparam int FLG_WDT  = 2;
  localparam int FLG_SW   = 3;
  localparam int FLG_STK  = 4;
  localparam int PRIO_BIT = 7;
  localparam int REG_W    = 8;

  typedef struct packed {
    logic pin;
    logic sleep;
    logic wdt;
    logic bor;
    logic sw;
    logic sfull;
    logic sunf;
  } req_t;

endpackage

// File: rtl/rstc_req_merge.sv
module rstc_req_merge
  import rstc_pkg::*;
(
  input  req_t              req_i,
  input  logic              bor_en_i,
  output logic              any_req_o,
  output logic              bor_eff_o,
  output logic [FLAG_W-1:0] set_o,
  output cause_e            cause_o
);

  logic bor_eff;

  assign bor_eff   = req_i.bor & bor_en_i;
  assign bor_eff_o = bor_eff;
  assign any_req_o = req_i.pin | req_i.wdt | req_i.sw | req_i.sfull | req_i.sunf | bor_eff;

  // event-to-flag mapping; power-on flag is only set by the block reset
  always_comb begin
    set_o          = '0;
    set_o[FLG_BOR] = bor_eff;
    set_o[FLG_WDT] = req_i.wdt;
    set_o[FLG_SW]  = req_i.sw;
    set_o[FLG_STK] = req_i.sfull | req_i.sunf;
  end

  // fixed-priority cause encoder
  always_comb begin
    if (bor_eff)         cause_o = CAUSE_BROWNOUT;
    else if (req_i.wdt)  cause_o = CAUSE_WATCHDOG;
    else if (req_i.pin)  cause_o = req_i.sleep ? CAUSE_PIN_SLEEP : CAUSE_PIN_RUN;
    else if (req_i.sw)   cause_o = CAUSE_SOFTWARE;
    else if (req_i.sfull) cause_o = CAUSE_STK_FULL;
    else if (req_i.sunf) cause_o = CAUSE_STK_UNDER;
    else                 cause_o = CAUSE_POWERON;
  end

endmodule

// File: rtl/rstc_pwrt.sv
module rstc_pwrt #(
  parameter int PU_TICKS = 2048
) (
  input  logic clk,
  input  logic por_i,
  input  logic tick_i,
  input  logic restart_i,
  output logic busy_o,
  output logic busy_nxt_o
);

  localparam int CW = (PU_TICKS > 2) ? $clog2(PU_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PU_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          busy_q, busy_nxt;

  always_comb begin
    busy_nxt = busy_q;
    cnt_nxt  = cnt_q;
    if (restart_i) begin
      busy_nxt = 1'b1;
      cnt_nxt  = '0;
    end else if (busy_q && tick_i) begin
      if (cnt_q == LAST) begin
        busy_nxt = 1'b0;
        cnt_nxt  = '0;
      end else begin
        cnt_nxt = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_nxt;
      cnt_q  <= cnt_nxt;
    end
  end

  assign busy_o     = busy_q;
  assign busy_nxt_o = busy_nxt;

  // R2: count only advances on a slow tick
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (por_i)
    (busy_q && !tick_i && !restart_i) |=> $stable(cnt_q));

  // R2: the delay ends only on a tick
  a_r2_release_on_tick: assert property (@(posedge clk) disable iff (por_i)
    $fell(busy_q) |-> $past(tick_i));

  // R4: an enabled brown-out always re-arms the delay
  a_r4_restart_arms: assert property (@(posedge clk) disable iff (por_i)
    restart_i |=> (busy_q && cnt_q == '0));

endmodule

// File: rtl/rstc_status.sv
module rstc_status
  import rstc_pkg::*;
(
  input  logic              clk,
  input  logic              por_i,
  input  logic [FLAG_W-1:0] set_i,
  input  logic              cause_vld_i,
  input  cause_e            cause_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              re_i,
  output logic [REG_W-1:0]  rdata_o,
  output cause_e            cause_o
);

  logic [FLAG_W-1:0] flags_q, flags_nxt, clr;
  logic              prio_q;
  cause_e            cause_q;
  logic [REG_W-1:0]  word, rdata_q;

  assign clr       = we_i ? ~wdata_i[FLAG_W-1:0] : '0;
  assign flags_nxt = (flags_q & ~clr) | set_i;

  always_comb begin
    word                = '0;
    word[FLAG_W-1:0]    = flags_q;
    word[PRIO_BIT]      = prio_q;
  end

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      flags_q <= FLAG_W'(1) << FLG_POR;
      prio_q  <= 1'b0;
      cause_q <= CAUSE_POWERON;
      rdata_q <= '0;
    end else begin
      flags_q <= flags_nxt;
      if (we_i)        prio_q  <= wdata_i[PRIO_BIT];
      if (cause_vld_i) cause_q <= cause_i;
      if (re_i)        rdata_q <= word;
    end
  end

  assign rdata_o = rdata_q;
  assign cause_o = cause_q;

  // R5/R6: an event always leaves its flag set, even against a clear
  for (genvar k = 0; k < FLAG_W; k++) begin : g_flag_chk
    a_r6_set_wins: assert property (@(posedge clk) disable iff (por_i)
      set_i[k] |=> flags_q[k]);
  end

  // R7: unused bits read zero
  a_r7_gap_zero: assert property (@(posedge clk) disable iff (por_i)
    rdata_q[6:5] == 2'b00);

  // R8: read data holds between reads
  a_r8_read_hold: assert property (@(posedge clk) disable iff (por_i)
    !re_i |=> $stable(rdata_q));

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rstc_pkg::*;
#(
  parameter int PU_TICKS = 2048
) (
  input  logic       clk,
  input  logic       por_req,
  input  logic       lf_tick,
  input  logic       ext_rst_req,
  input  logic       in_sleep,
  input  logic       wdt_expire,
  input  logic       bor_detect,
  input  logic       bor_enable,
  input  logic       sw_reset,
  input  logic       stk_full,
  input  logic       stk_underflow,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  input  logic       reg_re,
  output logic [7:0] reg_rdata,
  output logic [2:0] reset_cause,
  output logic       chip_rst
);

  req_t              req;
  logic              any_req, bor_eff, busy, busy_nxt;
  logic [FLAG_W-1:0] set_vec;
  cause_e            cause_nxt, cause_cur;
  logic              rst_q;

  always_comb begin
    req.pin   = ext_rst_req;
    req.sleep = in_sleep;
    req.wdt   = wdt_expire;
    req.bor   = bor_detect;
    req.sw    = sw_reset;
    req.sfull = stk_full;
    req.sunf  = stk_underflow;
  end

  rstc_req_merge u_merge (
    .req_i     (req),
    .bor_en_i  (bor_enable),
    .any_req_o (any_req),
    .bor_eff_o (bor_eff),
    .set_o     (set_vec),
    .cause_o   (cause_nxt)
  );

  rstc_pwrt #(.PU_TICKS(PU_TICKS)) u_pwrt (
    .clk        (clk),
    .por_i      (por_req),
    .tick_i     (lf_tick),
    .restart_i  (bor_eff),
    .busy_o     (busy),
    .busy_nxt_o (busy_nxt)
  );

  rstc_status u_status (
    .clk         (clk),
    .por_i       (por_req),
    .set_i       (set_vec),
    .cause_vld_i (any_req),
    .cause_i     (cause_nxt),
    .we_i        (reg_we),
    .wdata_i     (reg_wdata),
    .re_i        (reg_re),
    .rdata_o     (reg_rdata),
    .cause_o     (cause_cur)
  );

  // set/reset latch: any request sets, timer completion with no request releases
  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) rst_q <= 1'b1;
    else         rst_q <= any_req | busy_nxt;
  end

  assign chip_rst    = rst_q;
  assign reset_cause = cause_cur;

  // R3: a request is reflected on the chip reset at the next edge
  a_r3_req_sets_rst: assert property (@(posedge clk) disable iff (por_req)
    any_req |=> chip_rst);

  // R2: reset never drops while the power-up delay is still running
  a_r2_held_while_busy: assert property (@(posedge clk) disable iff (por_req)
    busy |-> chip_rst);

endmodule

// File: tb/tb_reset_sequencer.sv
module tb_reset_sequencer;

  localparam int T = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic por = 1'b1, tick = 0, pin = 0, slp = 0, wdt = 0, bor = 0, bor_en = 0;
  logic sw = 0, sfull = 0, sunf = 0, we = 0, re = 0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] cause;
  logic       rst;

  reset_sequencer #(.PU_TICKS(T)) dut (
    .clk(clk), .por_req(por), .lf_tick(tick), .ext_rst_req(pin), .in_sleep(slp),
    .wdt_expire(wdt), .bor_detect(bor), .bor_enable(bor_en), .sw_reset(sw),
    .stk_full(sfull), .stk_underflow(sunf), .reg_we(we), .reg_wdata(wdata),
    .reg_re(re), .reg_rdata(rdata), .reset_cause(cause), .chip_rst(rst)
  );

  int n_chk = 0, n_fail = 0;
  logic [4:0] m_flags; logic m_prio; logic [2:0] m_cause;
  logic m_busy; int m_cnt; logic m_rst; logic [7:0] m_rdata;

  function automatic logic [7:0] m_word();
    return {m_prio, 2'b00, m_flags};
  endfunction

  function automatic logic [2:0] m_code(logic b, logic w, logic p, logic s, logic s2, logic f, logic u);
    if (b) return 3'd4;
    if (w) return 3'd3;
    if (p) return s ? 3'd2 : 3'd1;
    if (s2) return 3'd5;
    if (f) return 3'd6;
    if (u) return 3'd7;
    return 3'd0;
  endfunction

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic be, rq; logic [4:0] setv, clr; logic [7:0] old;
    if (por) begin
      m_flags = 5'b00001; m_prio = 0; m_cause = 0;
      m_busy = 1; m_cnt = 0; m_rst = 1; m_rdata = 0;
      return;
    end
    be = bor & bor_en;
    rq = pin | wdt | sw | sfull | sunf | be;
    old = m_word();
    if (be) begin m_busy = 1; m_cnt = 0; end
    else if (m_busy && tick) begin
      if (m_cnt == T-1) begin m_busy = 0; m_cnt = 0; end else m_cnt++;
    end
    m_rst = rq | m_busy;
    setv = {sfull | sunf, sw, wdt, be, 1'b0};
    clr = we ? ~wdata[4:0] : 5'b0;
    m_flags = (m_flags & ~clr) | setv;
    if (we) m_prio = wdata[7];
    if (rq) m_cause = m_code(be, wdt, pin, slp, sw, sfull, sunf);
    if (re) m_rdata = old;
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, "chip_rst", {7'b0, rst}, {7'b0, m_rst});
    chk(tag, "reg_rdata", rdata, m_rdata);
    chk(tag, "reset_cause", {5'b0, cause}, {5'b0, m_cause});
  endtask

  task automatic quiet();
    tick = 0; pin = 0; slp = 0; wdt = 0; bor = 0; sw = 0; sfull = 0; sunf = 0;
    we = 0; re = 0; wdata = '0;
  endtask

  task automatic rd(string tag);
    re = 1; step(tag); re = 0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    model_edge();
    // R1: reset state during and after power-on
    repeat (3) step("R1");
    @(negedge clk); por = 0;
    rd("R1");
    chk("R1", "status after por", rdata, 8'h01);
    // R2: cycles without ticks do not advance the delay
    repeat (8) step("R2");
    for (int i = 0; i < T; i++) begin
      tick = 1; step("R2"); tick = 0; step("R2"); step("R2");
    end
    chk("R2", "released", {7'b0, rst}, 8'h00);
    // R10 and R9: pin during run and during sleep, no flag
    pin = 1; step("R10"); step("R10"); pin = 0; step("R3"); step("R3");
    pin = 1; slp = 1; step("R10"); pin = 0; slp = 0; step("R10");
    rd("R10");
    // R5: each event sets its flag
    wdt = 1; step("R5"); wdt = 0;
    sw = 1; step("R5"); sw = 0;
    sfull = 1; step("R5"); sfull = 0;
    sunf = 1; step("R9"); sunf = 0;
    step("R3"); rd("R5");
    // R4: brown-out masked when disabled
    bor = 1; step("R4"); bor = 0; step("R4"); rd("R4");
    chk("R4", "masked bor", {7'b0, rst}, 8'h00);
    bor_en = 1; bor = 1; step("R4"); bor = 0;
    repeat (3) begin tick = 1; step("R4"); tick = 0; step("R4"); end
    // R3: a watchdog request during the delay does not restart it
    wdt = 1; step("R3"); wdt = 0;
    repeat (T) begin tick = 1; step("R3"); tick = 0; step("R3"); end
    rd("R5");
    // R6: write ones has no effect, zeros clear, set wins over clear
    we = 1; wdata = 8'h1F; step("R6"); we = 0; rd("R6");
    we = 1; wdata = 8'h80; wdt = 1; step("R6"); we = 0; wdt = 0; rd("R6");
    // R7: priority enable and zero gap
    we = 1; wdata = 8'hE4; step("R7"); we = 0; rd("R7");
    we = 1; wdata = 8'h04; step("R7"); we = 0;
    // R8: read data holds without re
    step("R8"); step("R8"); rd("R8");
    // R9: simultaneous requests resolve by priority
    wdt = 1; pin = 1; sw = 1; step("R9"); quiet(); step("R9");
    sfull = 1; sunf = 1; step("R9"); quiet(); step("R9");
    pin = 1; sunf = 1; slp = 1; step("R9"); quiet(); step("R9");
    // random phase
    for (int c = 0; c < 4000; c++) begin
      tick   = ($urandom % 3) == 0;
      pin    = ($urandom % 40) == 0;
      slp    = $urandom % 2;
      wdt    = ($urandom % 60) == 0;
      bor    = ($urandom % 80) == 0;
      bor_en = ($urandom % 4) != 0;
      sw     = ($urandom % 60) == 0;
      sfull  = ($urandom % 90) == 0;
      sunf   = ($urandom % 90) == 0;
      we     = ($urandom % 8) == 0;
      re     = ($urandom % 3) == 0;
      wdata  = 8'($urandom);
      step("R3 R6 R9");
    end
    quiet();
    // R1: a second power-on mid-run resets everything
    @(negedge clk); por = 1;
    step("R1"); step("R1");
    por = 0; rd("R1");
    chk("R1", "status after second por", rdata, 8'h01);
    finish_run();
  end

endmodule